// File: doc/BRIEF.md
# Counter Start-Point Synchronizer

This block gives a time-to-digital converter's counter chain a well-defined zero point in a system whose clocks only run during power-pulsed acquisition windows. Counting is not anchored to the moment acquisition is switched on. The block waits for the release of reset and then counts a programmable number of system-clock periods. Only after that does it raise a start flag. The wait is chosen long enough to cover PLL lock and clock-receiver settling, so counting never begins on an unstable clock.

The block runs on the fast phase clock. That clock carries one step of the middle counter per cycle, and `PHASES` of its cycles make one system-clock period. A single-cycle strobe, `sys_stb`, marks each system-clock period. From the cycle in which start is raised, the middle counter steps through its phase indices from zero. The coarse counter advances by one each time the middle counter wraps, so a coarse step always lines up with a middle-counter wrap. Both counters hold at zero until start is raised.

Top module: `ssync_start_point`

## Requirements
- R1: A high `rst` at a clock edge clears `start_o`, `mid_o` and `coarse_o` to zero at that edge (synchronous, active high). This holds whether or not the block was already counting.
- R2: `wait_cfg` is captured only while `rst` is high. Changing it after reset is released has no effect on when `start_o` rises.
- R3: After reset is released, `start_o` goes high at the clock edge where the (W+1)-th `sys_stb` pulse is sampled, with W the captured wait count. Strobes seen during reset are not counted.
- R4: With a captured wait count of zero, `start_o` goes high at the edge of the first `sys_stb` after reset is released.
- R5: While `start_o` is low, `mid_o` and `coarse_o` are both zero.
- R6: In the first cycle with `start_o` high, `mid_o` is 0. It then rises by one every clock and wraps from PHASES-1 (7 by default) to 0. In cycle k counted from start, it equals k mod PHASES.
- R7: `coarse_o` is 0 in the first start cycle. It rises by one exactly on the edges where `mid_o` wraps from PHASES-1 to 0, so in cycle k from start it equals floor(k/PHASES).
- R8: `coarse_o` is COARSE_W bits wide (15 by default) and wraps from its maximum value to zero.
- R9: Once high, `start_o` stays high until `rst` is asserted again, regardless of `sys_stb` or `wait_cfg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast phase clock, PHASES cycles per system-clock period |
| rst | input | 1 | Synchronous active-high reset; its release is the reference point |
| sys_stb | input | 1 | Single-cycle pulse marking each system-clock period |
| wait_cfg | input | WAIT_W | Number of system-clock periods to wait after the first one; captured during reset |
| start_o | output | 1 | High from the counting start point until the next reset |
| mid_o | output | $clog2(PHASES) | Middle (phase) counter |
| coarse_o | output | COARSE_W | Coarse counter, one step per middle-counter wrap |

## Verification
The assertions assume that `sys_stb` is a single-cycle pulse that is never high in two consecutive cycles. They also assume that `rst` is held for at least one edge before the first check. The stimulus sends strobes at a fixed spacing of PHASES cycles, starting from a swept offset after reset release. It always begins with a reset of several cycles, and during that reset the strobes keep running so that the ignore rule of R3 is exercised. The bench also drives a different `wait_cfg` value after release. This shows that only the value captured during reset sets the start point.

// File: rtl/ssync_pkg.sv
package ssync_pkg;

    // Sequencing state of the start-point timer.
    typedef enum logic {
        SS_WAIT = 1'b0,
        SS_RUN  = 1'b1
    } ss_state_e;

    // True when v is a power of two (the phase index must wrap naturally).
    function automatic bit is_pow2(input int unsigned v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/ssync_wait_timer.sv
module ssync_wait_timer
    import ssync_pkg::*;
#(
    parameter int WAIT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sys_stb,
    input  logic [WAIT_W-1:0] wait_cfg,
    output logic              run_o
);

    ss_state_e         state_q;
    logic [WAIT_W-1:0] seen_q;
    logic [WAIT_W-1:0] limit_q;
    logic              last_period;

    assign last_period = (seen_q == limit_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SS_WAIT;
            seen_q  <= '0;
            limit_q <= wait_cfg;
        end else if (state_q == SS_WAIT && sys_stb) begin
            if (last_period) begin
                state_q <= SS_RUN;
            end else begin
                seen_q <= seen_q + WAIT_W'(1);
            end
        end
    end

    assign run_o = (state_q == SS_RUN);

    // R3: entry into counting only happens on an edge carrying a strobe
    p_start_on_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == SS_RUN && $past(state_q) == SS_WAIT) |-> $past(sys_stb));

    // R2: captured limit does not move outside reset
    p_limit_frozen_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(limit_q));

endmodule

// File: rtl/ssync_phase_ctr.sv
module ssync_phase_ctr #(
    parameter int PHASES = 8,
    localparam int MID_W = $clog2(PHASES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    output logic [MID_W-1:0] mid_o,
    output logic             wrap_o
);

    localparam logic [MID_W-1:0] LAST = MID_W'(PHASES - 1);

    logic [MID_W-1:0] mid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mid_q <= '0;
        end else if (run) begin
            mid_q <= mid_q + MID_W'(1);
        end
    end

    assign mid_o  = mid_q;
    assign wrap_o = run && (mid_q == LAST);

    // R6: phase index steps by one each cycle while counting
    p_mid_step_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(run) && run) |-> (mid_q == $past(mid_q) + MID_W'(1)));

endmodule

// File: rtl/ssync_coarse_ctr.sv
module ssync_coarse_ctr #(
    parameter int COARSE_W = 15
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                step,
    output logic [COARSE_W-1:0] coarse_o
);

    logic [COARSE_W-1:0] coarse_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            coarse_q <= '0;
        end else if (step) begin
            coarse_q <= coarse_q + COARSE_W'(1);
        end
    end

    assign coarse_o = coarse_q;

    // R8: full value rolls over to zero on a step
    p_coarse_wrap_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(step) && $past(coarse_q) == {COARSE_W{1'b1}}) |-> (coarse_q == '0));

endmodule

// File: rtl/ssync_start_point.sv
module ssync_start_point
    import ssync_pkg::*;
#(
    parameter int PHASES   = 8,
    parameter int COARSE_W = 15,
    parameter int WAIT_W   = 16,
    localparam int MID_W   = $clog2(PHASES)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sys_stb,
    input  logic [WAIT_W-1:0]   wait_cfg,
    output logic                start_o,
    output logic [MID_W-1:0]    mid_o,
    output logic [COARSE_W-1:0] coarse_o
);

    if (!is_pow2(PHASES) || PHASES < 2) begin : g_bad_phases
        initial $error("PHASES must be a power of two of at least 2");
    end

    logic run;
    logic wrap;

    ssync_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .sys_stb  (sys_stb),
        .wait_cfg (wait_cfg),
        .run_o    (run)
    );

    ssync_phase_ctr #(.PHASES(PHASES)) u_phase (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .mid_o  (mid_o),
        .wrap_o (wrap)
    );

    ssync_coarse_ctr #(.COARSE_W(COARSE_W)) u_coarse (
        .clk      (clk),
        .rst      (rst),
        .step     (wrap),
        .coarse_o (coarse_o)
    );

    assign start_o = run;

    // R1: reset clears everything at the next edge
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!start_o && mid_o == '0 && coarse_o == '0));

    // R9: start stays high until reset
    p_start_hold_r9: assert property (@(posedge clk) disable iff (rst)
        start_o |=> start_o);

    // R5: counters idle at zero before start
    p_idle_zero_r5: assert property (@(posedge clk) disable iff (rst)
        !start_o |-> (mid_o == '0 && coarse_o == '0));

    // R7: coarse moves exactly when the phase index wraps
    p_coarse_align_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(start_o) && start_o) |->
        (coarse_o == $past(coarse_o) + COARSE_W'($past(mid_o) == MID_W'(PHASES - 1))));

    // stimulus assumption: strobe is a single-cycle pulse
    p_strobe_single: assert property (@(posedge clk) disable iff (rst)
        sys_stb |=> !sys_stb);

endmodule

// File: tb/tb_ssync_start_point.sv
module tb_ssync_start_point;

    localparam int PH  = 8;
    localparam int CW  = 6;
    localparam int WW  = 6;
    localparam int MW  = $clog2(PH);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sys_stb = 1'b0;
    logic [WW-1:0] wait_cfg = '0;
    logic          start_o;
    logic [MW-1:0] mid_o;
    logic [CW-1:0] coarse_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    ssync_start_point #(.PHASES(PH), .COARSE_W(CW), .WAIT_W(WW)) dut (
        .clk(clk), .rst(rst), .sys_stb(sys_stb), .wait_cfg(wait_cfg),
        .start_o(start_o), .mid_o(mid_o), .coarse_o(coarse_o)
    );

    task automatic check(input string req, input int act_s, input int act_m,
                         input int act_c, input int exp_s, input int exp_m,
                         input int exp_c);
        n_chk++;
        if (act_s != exp_s || act_m != exp_m || act_c != exp_c) begin
            n_fail++;
            $display("FAIL %s: start/mid/coarse = %0d/%0d/%0d expected %0d/%0d/%0d",
                     req, act_s, act_m, act_c, exp_s, exp_m, exp_c);
        end
    endtask

    // R1: reset for a few cycles with strobes running, outputs zero
    task automatic do_reset(input int wcfg, input int cycles);
        for (int i = 0; i < cycles; i++) begin
            rst      = 1'b1;
            wait_cfg = WW'(wcfg);
            sys_stb  = (i % 2 == 0);
            @(posedge clk);
            @(negedge clk);
            check("R1", start_o, mid_o, coarse_o, 0, 0, 0);
        end
        sys_stb = 1'b0;
        rst     = 1'b0;
    endtask

    // Run after release: strobes at t = off + PH*j; start after strobe W+1
    task automatic do_run(input int wcfg, input int off, input int len);
        int t_start;
        t_start = off + PH * wcfg;
        for (int t = 0; t < len; t++) begin
            sys_stb  = (t >= off) && ((t - off) % PH == 0);
            wait_cfg = WW'(wcfg + 3 + t);   // R2: post-release changes ignored
            @(posedge clk);
            @(negedge clk);
            if (t < t_start) begin
                check(wcfg == 0 ? "R4/R5" : "R2/R3/R5", start_o, mid_o, coarse_o, 0, 0, 0);
            end else begin
                int k = t - t_start;
                check(k >= PH * (1 << CW) ? "R8/R9" : "R6/R7/R9", start_o, mid_o, coarse_o,
                      1, k % PH, (k / PH) % (1 << CW));
            end
        end
        sys_stb = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        // sweep of small wait counts against every strobe offset
        for (int w = 0; w < 6; w++) begin
            for (int off = 0; off < PH; off++) begin
                do_reset(w, 3);
                do_run(w, off, off + PH * w + 3 * PH + 5);
            end
        end
        // maximum wait count
        do_reset((1 << WW) - 1, 2);
        do_run((1 << WW) - 1, 2, 2 + PH * ((1 << WW) - 1) + 20);
        // long run through a coarse wrap (R8), then reset mid-run (R1, R9)
        do_reset(1, 2);
        do_run(1, 5, 5 + PH + PH * (1 << CW) + 3 * PH);
        do_reset(0, 2);
        do_run(0, 0, 12);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule